// File: doc/BRIEF.md
# Set/Clear GPIO Data and Direction Registers

This block holds the output-data and direction state of a GPIO port of up to 32 lines. It sits on a simple 32-bit memory-mapped register bus with address, write strobe, write data, read strobe and read data. Software never has to read, modify and write these registers. It changes the output levels and the directions by writing ones to a dedicated "set" address or a dedicated "clear" address, and every bit written as zero keeps its old value.

Each line drives its pad with the stored data bit and enables the pad driver with its direction bit. The raw pad levels pass through a two-flop synchronizer, and software reads them at an external-port address. The direction state can be read back. The output-data state cannot be read, because no address returns it. A parameter sets how many lines are implemented. Every bit above that count is tied to zero.

Top module: `gpio_setclr_regs`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `bus_rdata` are all zero, so every line starts as an input driving zero.
- R2: A write to offset 0x00 sets each output-data bit where `bus_wdata` is one and leaves the other bits unchanged. `pin_out` shows the new value from the rising edge that takes the write.
- R3: A write to offset 0x04 clears each output-data bit where `bus_wdata` is one and leaves the other bits unchanged. Its timing is the same as R2.
- R4: A write to offset 0x10 turns each line where `bus_wdata` is one into an output, and offset 0x14 turns each such line back into an input. `pin_oe` bit n is one exactly when line n is an output, with the timing of R2.
- R5: A read of offset 0x18 returns the direction vector, one meaning output. `bus_rdata` carries the result during the cycle after the rising edge that samples `bus_rd`, and it is zero in any cycle that follows an edge with no read.
- R6: A read of offset 0x80 returns the pad levels after two synchronizer flops. A level applied before rising edge k appears in a read whose sampling edge is k+2, and a read sampled at edge k+1 still returns the previous level.
- R7: Reads of offsets 0x00, 0x04, 0x10, 0x14 and any other address return zero, so the output-data state is never visible on the bus. Writes to 0x18, 0x80 or any other address have no effect on `pin_out` or `pin_oe`.
- R8: With LINES below 32, bits LINES and above of `pin_out`, `pin_oe` and `bus_rdata` are always zero, whatever is written or applied on `pin_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Output level for each line |
| pin_oe | output | 32 | Output enable for each line |

## Verification
Register writes land on the same rising edge that samples them. The bench therefore drives the write at a falling edge and checks `pin_out` and `pin_oe` at the next falling edge. Read data lags the read strobe by one edge, so each read is checked at the falling edge after the strobe is taken. The external-port path adds two synchronizer edges in front of the read register. The bench reads once one edge too early and expects the old level, then reads one edge later and expects the new level. A second instance with eight lines covers the masking of the upper bits.

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam logic [32:0] SPAN  = (33'd1 << LINES) - 33'd1;
  localparam logic [31:0] LMASK = SPAN[31:0];

  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_DIR_SET = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_DIR_ST  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_EXT     = ADDR_W'('h80);

  logic [31:0] dout_q, dir_q, sync1_q, sync2_q, rdata_q, rd_mux, wmask;

  assign wmask = bus_wdata & LMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OUT_SET: dout_q <= dout_q | wmask;
        A_OUT_CLR: dout_q <= dout_q & ~wmask;
        A_DIR_SET: dir_q  <= dir_q | wmask;
        A_DIR_CLR: dir_q  <= dir_q & ~wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & LMASK;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR_ST: rd_mux = dir_q;
      A_EXT:    rd_mux = sync2_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign pin_out   = dout_q;
  assign pin_oe    = dir_q;
  assign bus_rdata = rdata_q;

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OUT_SET) |=>
      ((pin_out & $past(wmask)) == $past(wmask)) &&
      ((pin_out & ~$past(wmask)) == ($past(pin_out) & ~$past(wmask))));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OUT_CLR) |=>
      ((pin_out & $past(wmask)) == 32'd0) &&
      ((pin_out & ~$past(wmask)) == ($past(pin_out) & ~$past(wmask))));

  // R4
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR_SET) |=>
      ((pin_oe & $past(wmask)) == $past(wmask)));

  // R4
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR_CLR) |=> ((pin_oe & $past(wmask)) == 32'd0));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_OUT_SET || bus_addr == A_OUT_CLR)) |=> $stable(pin_out));

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_DIR_SET || bus_addr == A_DIR_CLR)) |=> $stable(pin_oe));

  // R5
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DIR_ST) |=> bus_rdata == $past(pin_oe));

  // R5
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe | bus_rdata) & ~LMASK) == 32'd0);
endmodule

// File: tb/gpio_setclr_regs_test.sv
module gpio_setclr_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic [31:0] n_rdata, n_out, n_oe;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_regs #(.LINES(32), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  gpio_setclr_regs #(.LINES(8), .ADDR_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(n_rdata),
    .pin_in(pin_in), .pin_out(n_out), .pin_oe(n_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_data;
    do_write(8'h00, 32'h0000_00F0);
    check("R2 set", pin_out, 32'h0000_00F0);
    do_write(8'h00, 32'hA500_0003);
    check("R2 set keeps others", pin_out, 32'hA500_00F3);
    do_write(8'h04, 32'h0000_0030);
    check("R3 clear", pin_out, 32'hA500_00C3);
    do_write(8'h04, 32'hFFFF_0000);
    check("R3 clear upper", pin_out, 32'h0000_00C3);
  endtask

  task automatic t_dir;
    do_write(8'h10, 32'h8000_0F01);
    check("R4 dir set", pin_oe, 32'h8000_0F01);
    do_write(8'h14, 32'h0000_0300);
    check("R4 dir clear", pin_oe, 32'h8000_0C01);
    check("R4 data unaffected", pin_out, 32'h0000_00C3);
    do_read(8'h18);
    check("R5 dir read", bus_rdata, 32'h8000_0C01);
    @(negedge clk);
    check("R5 idle zero", bus_rdata, 32'h0);
  endtask

  task automatic t_ext;
    pin_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    pin_in = 32'hCAFE_0055;
    do_read(8'h80);
    check("R6 read at k", bus_rdata, 32'h1234_5678);
    do_read(8'h80);
    check("R6 read at k+1 old", bus_rdata, 32'h1234_5678);
    do_read(8'h80);
    check("R6 read at k+2 new", bus_rdata, 32'hCAFE_0055);
  endtask

  task automatic t_hidden;
    do_read(8'h00);
    check("R7 set addr reads zero", bus_rdata, 32'h0);
    do_read(8'h04);
    check("R7 clr addr reads zero", bus_rdata, 32'h0);
    do_read(8'h10);
    check("R7 dir set reads zero", bus_rdata, 32'h0);
    do_read(8'h14);
    check("R7 dir clr reads zero", bus_rdata, 32'h0);
    do_read(8'h3C);
    check("R7 unmapped reads zero", bus_rdata, 32'h0);
    do_write(8'h18, 32'hFFFF_FFFF);
    do_write(8'h80, 32'hFFFF_FFFF);
    do_write(8'h08, 32'hFFFF_FFFF);
    check("R7 ro write out", pin_out, 32'h0000_00C3);
    check("R7 ro write oe", pin_oe, 32'h8000_0C01);
  endtask

  task automatic t_narrow;
    do_write(8'h00, 32'hFFFF_FFFF);
    check("R8 narrow out", n_out, 32'h0000_00FF);
    do_write(8'h10, 32'hFFFF_FFFF);
    check("R8 narrow oe", n_oe, 32'h0000_00FF);
    do_read(8'h18);
    check("R8 narrow dir read", n_rdata, 32'h0000_00FF);
    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    do_read(8'h80);
    check("R8 narrow ext read", n_rdata, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_dir();
    t_ext();
    t_hidden();
    t_narrow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule